// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects a set of maskable peripheral interrupt requests and a small group of non-maskable trap requests and reduces them to one interrupt request toward a CPU. Alongside the request it presents the vector number of the winning source and the program address of that vector's table slot. Trap inputs occupy the lowest vector numbers and always beat maskable sources. Maskable source `i` uses vector `NUM_TRAP + i`.

Each maskable source has its own enable bit and a 3-bit user priority. A source competes only if its priority is strictly above the CPU's current priority. Arbitration has two tiers. The higher user level wins, and among sources on the same level the lower vector number wins. When the CPU acknowledges a presented request, the block records the level that was taken. It then withdraws the request and freezes the vector outputs for a fixed entry window, whose length does not depend on which source won. After the window it resumes arbitration.

Top module: `irq_vec_ctrl`

## Requirements
- R1: During and right after reset, `irqReq` is 0, `vecNum` is 0, `vecAddr` is 0x000004 and `grantLvl` is 0.
- R2: Trap input `k` maps to vector `k` (0 to NUM_TRAP-1). Any pending trap wins over every maskable source, whatever the enables or `cpuPrio` are, and the lowest-numbered pending trap wins.
- R3: Maskable source `i` (priority field at bits `i*3 +: 3` of `srcPrio`) maps to vector `NUM_TRAP+i`. It is a candidate only when its request and enable are both 1 and its priority is strictly greater than `cpuPrio`, so a priority of 0 never wins.
- R4: Among maskable candidates, the one with the highest priority value wins.
- R5: Among maskable candidates on the same priority value, the one with the lowest vector number wins.
- R6: While arbitrating, `irqReq`, `vecNum` and `vecAddr` reflect the inputs sampled at the previous rising clock edge. If there is no candidate, `irqReq` is 0 and `vecNum` keeps its previous value.
- R7: `vecAddr` always equals 0x000004 + 2 × `vecNum`.
- R8: An `ack` seen while `irqReq` is 1 loads `grantLvl` one cycle later with the level of the presented vector: 8 for a trap, otherwise the source priority. An `ack` while `irqReq` is 0 has no effect.
- R9: After an accepted `ack`, `irqReq` stays 0 and `vecNum`/`vecAddr` stay frozen for exactly ENTRY_CYC (default 3) cycles, whatever source won. The edge that follows loads a fresh arbitration result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| trapReq | input | NUM_TRAP | Non-maskable trap requests, bit k is vector k |
| srcReq | input | NUM_SRC | Maskable source pending flags |
| srcEn | input | NUM_SRC | Maskable source enables |
| srcPrio | input | NUM_SRC*PRIO_W | Per-source user priority, 3 bits per source |
| cpuPrio | input | PRIO_W | Current CPU priority |
| ack | input | 1 | CPU accepts the presented vector |
| irqReq | output | 1 | Interrupt request to the CPU |
| vecNum | output | VEC_W | Vector number presented |
| vecAddr | output | ADDR_W | Address of that vector's table slot |
| grantLvl | output | PRIO_W+1 | Level of the last accepted vector (8 for traps) |

## Verification
The assertions assume that `ack` carries meaning only while `irqReq` is high, and that the inputs are settled at each rising edge. The bench changes every input on the falling edge, so this holds. Acknowledges are also raised while `irqReq` is low, to show that such pulses are ignored rather than assumed away. Random stimulus keeps enables and traps sparse, so that arbitration windows with no candidate, ties on one level, and trap pre-emption all occur often. Directed cases pin down the exact winners.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // strobes from the control FSM to the arbitration datapath
  typedef struct packed {
    logic loadArb;   // register a fresh arbitration result
    logic capGrant;  // record taken level, drop request, freeze vector
  } irqStrobe_t;
endpackage

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int NUM_SRC  = 24,
  parameter int NUM_TRAP = 7,
  parameter int PRIO_W   = 3,
  parameter int ADDR_W   = 24,
  parameter logic [ADDR_W-1:0] BASE = 24'h000004,
  parameter int VEC_W    = 5,
  parameter int LVL_W    = PRIO_W + 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  irqStrobe_t                strb,
  input  logic [NUM_TRAP-1:0]       trapReq,
  input  logic [NUM_SRC-1:0]        srcReq,
  input  logic [NUM_SRC-1:0]        srcEn,
  input  logic [NUM_SRC*PRIO_W-1:0] srcPrio,
  input  logic [PRIO_W-1:0]         cpuPrio,
  output logic                      irqReq,
  output logic [VEC_W-1:0]          vecNum,
  output logic [ADDR_W-1:0]         vecAddr,
  output logic [LVL_W-1:0]          grantLvl
);
  localparam logic [LVL_W-1:0] TRAP_LVL = LVL_W'(1 << PRIO_W);

  logic [NUM_SRC-1:0] cand;
  logic               hit;
  logic [VEC_W-1:0]   winVec;
  logic [LVL_W-1:0]   winLvl;
  logic [LVL_W-1:0]   outLvl;

  // per-source eligibility: pending, enabled, above CPU level
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cand
    assign cand[g] = srcReq[g] & srcEn[g] &
                     (srcPrio[g*PRIO_W +: PRIO_W] > cpuPrio);
  end

  always_comb begin
    logic              tHit, mHit;
    logic [VEC_W-1:0]  tVec, mVec;
    logic [PRIO_W-1:0] mLvl;
    tHit = 1'b0;
    tVec = '0;
    for (int k = NUM_TRAP - 1; k >= 0; k--) begin
      if (trapReq[k]) begin
        tHit = 1'b1;
        tVec = VEC_W'(k);
      end
    end
    mHit = 1'b0;
    mVec = '0;
    mLvl = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand[i] && (!mHit || srcPrio[i*PRIO_W +: PRIO_W] > mLvl)) begin
        mHit = 1'b1;
        mVec = VEC_W'(NUM_TRAP + i);
        mLvl = srcPrio[i*PRIO_W +: PRIO_W];
      end
    end
    hit    = tHit | mHit;
    winVec = tHit ? tVec : mVec;
    winLvl = tHit ? TRAP_LVL : LVL_W'(mLvl);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqReq   <= 1'b0;
      vecNum   <= '0;
      vecAddr  <= BASE;
      outLvl   <= '0;
      grantLvl <= '0;
    end else if (strb.capGrant) begin
      irqReq   <= 1'b0;
      grantLvl <= outLvl;
    end else if (strb.loadArb) begin
      irqReq <= hit;
      if (hit) begin
        vecNum  <= winVec;
        vecAddr <= BASE + (ADDR_W'(winVec) << 1);
        outLvl  <= winLvl;
      end
    end
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int ENTRY_CYC = 3,
  localparam int CNT_W    = (ENTRY_CYC > 1) ? $clog2(ENTRY_CYC) : 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ack,
  input  logic       irqReq,
  output irqStrobe_t strb
);
  typedef enum logic {ST_ARB, ST_HOLD} ctlState_t;
  ctlState_t       state;
  logic [CNT_W-1:0] holdCnt;

  always_comb begin
    strb = '0;
    if (state == ST_ARB) begin
      strb.capGrant = ack & irqReq;
      strb.loadArb  = ~(ack & irqReq);
    end else begin
      strb.loadArb = (holdCnt == '0);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_ARB;
      holdCnt <= '0;
    end else if (state == ST_ARB) begin
      if (strb.capGrant) begin
        state   <= ST_HOLD;
        holdCnt <= CNT_W'(ENTRY_CYC - 1);
      end
    end else if (holdCnt == '0) begin
      state <= ST_ARB;
    end else begin
      holdCnt <= holdCnt - 1'b1;
    end
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_SRC   = 24,
  parameter int NUM_TRAP  = 7,
  parameter int PRIO_W    = 3,
  parameter int ADDR_W    = 24,
  parameter int ENTRY_CYC = 3,
  localparam int VEC_W    = $clog2(NUM_TRAP + NUM_SRC),
  localparam int LVL_W    = PRIO_W + 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_TRAP-1:0]       trapReq,
  input  logic [NUM_SRC-1:0]        srcReq,
  input  logic [NUM_SRC-1:0]        srcEn,
  input  logic [NUM_SRC*PRIO_W-1:0] srcPrio,
  input  logic [PRIO_W-1:0]         cpuPrio,
  input  logic                      ack,
  output logic                      irqReq,
  output logic [VEC_W-1:0]          vecNum,
  output logic [ADDR_W-1:0]         vecAddr,
  output logic [LVL_W-1:0]          grantLvl
);
  irqStrobe_t strb;

  irq_ctrl #(.ENTRY_CYC(ENTRY_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .ack(ack), .irqReq(irqReq), .strb(strb)
  );

  irq_datapath #(
    .NUM_SRC(NUM_SRC), .NUM_TRAP(NUM_TRAP), .PRIO_W(PRIO_W),
    .ADDR_W(ADDR_W), .BASE(ADDR_W'(4)), .VEC_W(VEC_W), .LVL_W(LVL_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .trapReq(trapReq),
    .srcReq(srcReq), .srcEn(srcEn), .srcPrio(srcPrio), .cpuPrio(cpuPrio),
    .irqReq(irqReq), .vecNum(vecNum), .vecAddr(vecAddr), .grantLvl(grantLvl)
  );
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk #(
  parameter int NUM_SRC   = 24,
  parameter int NUM_TRAP  = 7,
  parameter int PRIO_W    = 3,
  parameter int ADDR_W    = 24,
  parameter int ENTRY_CYC = 3,
  localparam int VEC_W    = $clog2(NUM_TRAP + NUM_SRC),
  localparam int LVL_W    = PRIO_W + 1
) (
  input logic                      clk,
  input logic                      rstN,
  input logic [NUM_TRAP-1:0]       trapReq,
  input logic [NUM_SRC-1:0]        srcReq,
  input logic [NUM_SRC-1:0]        srcEn,
  input logic [NUM_SRC*PRIO_W-1:0] srcPrio,
  input logic [PRIO_W-1:0]         cpuPrio,
  input logic                      ack,
  input logic                      irqReq,
  input logic [VEC_W-1:0]          vecNum,
  input logic [ADDR_W-1:0]         vecAddr,
  input logic [LVL_W-1:0]          grantLvl
);
  // cycles left in the entry window, tracked from the ports only
  int winLeft;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 winLeft <= 0;
    else if (ack && irqReq)    winLeft <= ENTRY_CYC;
    else if (winLeft != 0)     winLeft <= winLeft - 1;
  end

  // R7
  addr_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    vecAddr == ADDR_W'(4) + (ADDR_W'(vecNum) << 1));

  // R2
  trap_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (winLeft <= 1 && !(ack && irqReq) && trapReq != '0)
      |=> (irqReq && int'(vecNum) < NUM_TRAP));

  // R6
  idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (winLeft <= 1 && !(ack && irqReq) && trapReq == '0 && srcEn == '0)
      |=> !irqReq);

  // R9
  entry_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (winLeft != 0) |-> !irqReq);

  // R9
  entry_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ack && irqReq) || winLeft > 1 |=> $stable(vecNum) && $stable(vecAddr));

  // R8
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ack && irqReq) |=> $stable(grantLvl));

  // R8
  trap_lvl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ack && irqReq && int'(vecNum) < NUM_TRAP) |=> grantLvl == LVL_W'(1 << PRIO_W));
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .NUM_TRAP(NUM_TRAP), .PRIO_W(PRIO_W),
  .ADDR_W(ADDR_W), .ENTRY_CYC(ENTRY_CYC)
) u_chk (.*);

// File: tb/irq_vec_ctrl_tb.sv
module irq_vec_ctrl_tb;
  localparam int NS = 24, NT = 7, PW = 3, AW = 24, EC = 3;
  localparam int VW = $clog2(NT + NS), LW = PW + 1;

  logic clk = 1'b0, rstN = 1'b0;
  logic [NT-1:0] trapReq = '0;
  logic [NS-1:0] srcReq = '0, srcEn = '0;
  logic [NS*PW-1:0] srcPrio = '0;
  logic [PW-1:0] cpuPrio = '0;
  logic ack = 1'b0;
  logic irqReq;
  logic [VW-1:0] vecNum;
  logic [AW-1:0] vecAddr;
  logic [LW-1:0] grantLvl;

  int total = 0, bad = 0;
  bit done = 0;

  // reference state built from the requirements
  bit expIrq = 0;
  int expVec = 0, expOutLvl = 0, expGrant = 0, winLeft = 0;

  always #2 clk = ~clk;

  irq_vec_ctrl #(.NUM_SRC(NS), .NUM_TRAP(NT), .PRIO_W(PW), .ADDR_W(AW),
                 .ENTRY_CYC(EC)) u_dut (.*);

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void pickWinner(output bit hit, output int vec, output int lvl);
    hit = 0; vec = 0; lvl = 0;
    for (int k = 0; k < NT; k++)
      if (!hit && trapReq[k]) begin hit = 1; vec = k; lvl = 8; end
    if (hit) return;
    for (int i = 0; i < NS; i++) begin
      int p = int'(srcPrio[i*PW +: PW]);
      if (srcReq[i] && srcEn[i] && p > int'(cpuPrio) && (!hit || p > lvl)) begin
        hit = 1; vec = NT + i; lvl = p;
      end
    end
  endfunction

  // advance one clock with inputs already driven, update model, compare
  task automatic step(string req);
    bit h; int v, l;
    bit arb;
    pickWinner(h, v, l);
    arb = (winLeft <= 1);
    if (winLeft == 0 && ack && expIrq) begin
      expIrq = 0; expGrant = expOutLvl; winLeft = EC;
    end else begin
      if (winLeft > 0) winLeft--;
      if (arb) begin
        expIrq = h;
        if (h) begin expVec = v; expOutLvl = l; end
      end
    end
    @(posedge clk); #1;
    chk(req, "irqReq", int'(irqReq), int'(expIrq));
    chk(req, "vecNum", int'(vecNum), expVec);
    chk("R7", "vecAddr", int'(vecAddr), 4 + 2 * expVec);
    chk(req, "grantLvl", int'(grantLvl), expGrant);
    @(negedge clk);
  endtask

  task automatic clearIn();
    trapReq = '0; srcReq = '0; srcEn = '0; srcPrio = '0; cpuPrio = '0; ack = 0;
  endtask

  task automatic setSrc(int i, int p);
    srcReq[i] = 1; srcEn[i] = 1; srcPrio[i*PW +: PW] = PW'(p);
  endtask

  initial begin
    #9;
    // R1 reset state
    chk("R1", "irqReq", int'(irqReq), 0);
    chk("R1", "vecNum", int'(vecNum), 0);
    chk("R1", "vecAddr", int'(vecAddr), 4);
    chk("R1", "grantLvl", int'(grantLvl), 0);
    @(negedge clk); rstN = 1;
    step("R1");

    // R3: level equal to cpuPrio loses, above it wins
    clearIn(); cpuPrio = 3; setSrc(5, 3);
    step("R3"); chk("R3", "equal level idle", int'(irqReq), 0);
    setSrc(9, 4);
    step("R3"); chk("R3", "vec 7+9", int'(vecNum), 16);
    srcEn[9] = 0;
    step("R3"); chk("R3", "disabled idle", int'(irqReq), 0);
    chk("R6", "vec held", int'(vecNum), 16);

    // R4: higher level wins over lower index
    clearIn(); setSrc(2, 2); setSrc(20, 6);
    step("R4"); chk("R4", "vec", int'(vecNum), 27);

    // R5: tie on level, lowest vector wins
    clearIn(); setSrc(14, 5); setSrc(6, 5); setSrc(11, 5);
    step("R5"); chk("R5", "vec", int'(vecNum), 13);

    // R2: traps beat everything, lowest trap wins
    clearIn(); cpuPrio = 7; setSrc(0, 7); trapReq = 7'b0101000;
    step("R2"); chk("R2", "vec", int'(vecNum), 3);
    chk("R2", "req", int'(irqReq), 1);

    // R8: accepted ack captures trap level 8
    ack = 1;
    step("R8"); chk("R8", "grant trap", int'(grantLvl), 8);
    ack = 0; clearIn();
    // R9: quiet window of EC cycles
    for (int c = 1; c < EC; c++) begin
      setSrc(1, 7);
      step("R9"); chk("R9", "quiet", int'(irqReq), 0);
      chk("R9", "frozen", int'(vecNum), 3);
    end
    step("R9"); chk("R9", "resume", int'(irqReq), 1);
    chk("R9", "new vec", int'(vecNum), 8);

    // R8: ack while irqReq low is ignored
    clearIn(); step("R8");
    ack = 1; step("R8"); chk("R8", "ignored", int'(grantLvl), 8);
    ack = 0; setSrc(4, 2);
    step("R8"); ack = 1; step("R8"); chk("R8", "grant prio", int'(grantLvl), 2);
    ack = 0;

    // random mix
    void'($urandom(32'h1234abcd));
    for (int n = 0; n < 3000; n++) begin
      clearIn();
      cpuPrio = PW'($urandom_range(0, 7));
      for (int i = 0; i < NS; i++) begin
        srcReq[i] = ($urandom_range(0, 3) == 0);
        srcEn[i]  = ($urandom_range(0, 2) == 0);
        srcPrio[i*PW +: PW] = PW'($urandom_range(0, 7));
      end
      if ($urandom_range(0, 7) == 0) trapReq = NT'($urandom);
      ack = ($urandom_range(0, 3) == 0);
      step("R6");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule